// File: doc/BRIEF.md
# Two-Wire Bus Slave Front End

This block sits between the two pins of a two-wire serial bus and the command engine of a slave device. It runs on a system clock that is much faster than the bus clock and receives SCL and SDA already synchronised to that clock. It watches for start and stop conditions and shifts received bits into bytes. It compares the first byte after each start against a fixed device prefix and three strap inputs. When it is addressed it acknowledges, and during reads it shifts out the bytes that the command engine supplies. After every byte it sends, it reports whether the master acknowledged it.

The command engine sees a plain byte stream. A pulse marks each start and each stop. A valid strobe carries each received data byte, with a flag on the first byte after the select byte. A request strobe asks for the next byte to transmit, and a strobe with a flag reports the master's acknowledge. A busy input from the engine blocks the acknowledge of any select byte, so that a master can poll until an internal write has finished. The pin side is a single pull-down enable for an open-drain pad.

Top module: `twi_slave_front`

## Requirements
- R1: A falling SDA while SCL is high, sampled on two consecutive system clocks, raises `start_det` for one cycle. It also abandons any transfer in progress, including a partly received byte, and the next byte is treated as a select byte.
- R2: A rising SDA while SCL is high raises `stop_det` for one cycle, releases SDA and ends the transfer.
- R3: The select byte matches only when bits 7:4 equal 1010 and bits 3:1 equal the effective strap values A2, A1, A0. Bit 0 selects read (1) or write (0). An unmatched select gets no acknowledge, and the block ignores the bus until the next start, so later bytes produce no `rx_valid` and no acknowledge.
- R4: When a select byte matches, and for every data byte received after a matched write select, `sda_pull` is high throughout the ninth SCL pulse, so the master samples a low SDA.
- R5: While `busy` is high, no select byte is acknowledged, whether read or write.
- R6: Received data bytes are assembled MSB first and presented on `rx_byte` with a one-cycle `rx_valid`. `rx_first` is high with `rx_valid` only for the first data byte after a matched select.
- R7: After a matched read select, and after each master acknowledge, `tx_req` pulses once on the rising SCL of that ninth pulse. The value on `tx_byte` at the following SCL fall is sent MSB first. `sda_pull` changes only while SCL is low.
- R8: On the ninth SCL pulse of each sent byte, SDA is released, and `ack_valid` pulses with `master_ack` = 1 for a low SDA (ACK) or 0 for a high SDA (NACK). An ACK leads to another byte. A NACK keeps SDA released until the next start.
- R9: While `rst_n` is low, `sda_pull` and all strobes are 0 on the next clock.
- R10: Parameter `STRAP_WIRED` marks which strap bits come from the `strap` pins. Each unwired bit takes its value from `STRAP_TIE` (default 0), and the pin value of that bit has no effect on matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Synchronised SCL level |
| sda_in | input | 1 | Synchronised SDA level (wired bus value) |
| strap | input | 3 | Device address straps A2, A1, A0 (bit 2 = A2) |
| busy | input | 1 | Command engine busy; blocks select acknowledge |
| tx_byte | input | 8 | Next byte to transmit, valid by the SCL fall after `tx_req` |
| sda_pull | output | 1 | Open-drain pull-down enable for SDA |
| rx_byte | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle strobe: `rx_byte` is new |
| rx_first | output | 1 | With `rx_valid`: first data byte after select |
| tx_req | output | 1 | One-cycle request for the next transmit byte |
| ack_valid | output | 1 | One-cycle strobe: master acknowledge sampled |
| master_ack | output | 1 | 1 = master acknowledged the last sent byte |
| start_det | output | 1 | One-cycle pulse on a start condition |
| stop_det | output | 1 | One-cycle pulse on a stop condition |

## Verification
The assertions assume a legal master. It changes SDA only while SCL is low, except to make a start or stop. It holds each SCL level for several system clocks, and it never tries a start or stop while the slave is pulling SDA low. From these assumptions the checks that pull-down changes happen only with SCL low, and that start, stop and master-acknowledge events see a released line, follow. The bench master keeps every SCL half period at eight system clocks. It sets SDA right after an SCL fall and samples the bus in the middle of the high phase, so every transition it makes falls inside those assumptions.

// File: rtl/twi_pkg.sv
// Package: shared constants and the transfer state type for the two-wire
// slave front end. Assumes byte-wide transfers on the bus.
package twi_pkg;
    localparam int BYTE_W   = 8;
    localparam int CNT_W    = $clog2(BYTE_W + 1);
    localparam int STRAP_W  = 3;
    localparam logic [3:0] SEL_PREFIX = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,   // ignoring the bus until a start
        ST_SEL,    // shifting in the select byte
        ST_SACK,   // ninth pulse after a matched select
        ST_RX,     // shifting in a data byte
        ST_RACK,   // ninth pulse after a received data byte
        ST_TX,     // shifting out a data byte
        ST_MACK    // ninth pulse, master acknowledge of a sent byte
    } twi_state_t;
endpackage

// File: rtl/twi_line_mon.sv
// Line monitor: registers the synchronised SCL and SDA levels and derives
// SCL edges plus start and stop events from two successive samples.
// Assumes inputs are already free of metastability; idle bus reads high.
module twi_line_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_bit,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_seen,
    output logic stop_seen
);
    logic scl_q, sda_q, scl_p, sda_p;

    // Two-deep sample history of both lines, reset to the idle-high level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
            scl_p <= scl_q;
            sda_p <= sda_q;
        end
    end

    // Edge and condition decode from the current and previous samples.
    always_comb begin
        sda_bit    = sda_q;
        scl_rise   = scl_q & ~scl_p;
        scl_fall   = ~scl_q & scl_p;
        start_seen = scl_q & scl_p & sda_p & ~sda_q;
        stop_seen  = scl_q & scl_p & ~sda_p & sda_q;
    end
endmodule

// File: rtl/twi_sel_match.sv
// Select matcher: compares a received select byte with the fixed prefix and
// the effective strap bits. Unwired strap bits take a parameterised tie value.
// Assumes the byte is stable when the engine consumes the result.
module twi_sel_match
    import twi_pkg::*;
#(
    parameter logic [STRAP_W-1:0] STRAP_WIRED = '1,
    parameter logic [STRAP_W-1:0] STRAP_TIE   = '0
) (
    input  logic [STRAP_W-1:0] strap,
    input  logic [BYTE_W-1:0]  sel_byte,
    input  logic               busy,
    output logic               sel_hit,
    output logic               sel_rd
);
    logic [STRAP_W-1:0] strap_eff;

    // Per-bit choice between the strap pin and its tie value.
    for (genvar i = 0; i < STRAP_W; i++) begin : g_strap
        if (STRAP_WIRED[i]) begin : g_pin
            assign strap_eff[i] = strap[i];
        end else begin : g_tie
            assign strap_eff[i] = STRAP_TIE[i];
        end
    end

    // Match result: prefix, straps, and not busy.
    always_comb begin
        sel_rd  = sel_byte[0];
        sel_hit = (sel_byte[BYTE_W-1 -: 4] == SEL_PREFIX)
                & (sel_byte[STRAP_W:1] == strap_eff)
                & ~busy;
    end
endmodule

// File: rtl/twi_byte_engine.sv
// Byte engine: the transfer state machine. It shifts bits in on SCL rises,
// drives the pull-down on SCL falls, acknowledges, and strobes the command
// engine. Assumes clean edge and condition pulses from the line monitor.
module twi_byte_engine
    import twi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_bit,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_seen,
    input  logic              stop_seen,
    input  logic              sel_hit,
    input  logic              sel_rd,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic [BYTE_W-1:0] shreg,
    output logic              sda_pull,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              rx_first,
    output logic              tx_req,
    output logic              ack_valid,
    output logic              master_ack,
    output logic              start_det,
    output logic              stop_det
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    twi_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] txsh;
    logic              rd_mode;
    logic              first_pend;
    logic              mack_q;

    // Transfer sequencing; start outranks stop, which outranks bit events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            shreg      <= '0;
            txsh       <= '0;
            rd_mode    <= 1'b0;
            first_pend <= 1'b0;
            mack_q     <= 1'b0;
            sda_pull   <= 1'b0;
            rx_byte    <= '0;
            rx_valid   <= 1'b0;
            rx_first   <= 1'b0;
            tx_req     <= 1'b0;
            ack_valid  <= 1'b0;
            master_ack <= 1'b0;
            start_det  <= 1'b0;
            stop_det   <= 1'b0;
        end else begin
            rx_valid  <= 1'b0;
            rx_first  <= 1'b0;
            tx_req    <= 1'b0;
            ack_valid <= 1'b0;
            start_det <= 1'b0;
            stop_det  <= 1'b0;
            if (start_seen) begin
                start_det  <= 1'b1;
                state      <= ST_SEL;
                cnt        <= '0;
                sda_pull   <= 1'b0;
                first_pend <= 1'b0;
            end else if (stop_seen) begin
                stop_det   <= 1'b1;
                state      <= ST_IDLE;
                sda_pull   <= 1'b0;
                first_pend <= 1'b0;
            end else begin
                unique case (state)
                    ST_SEL, ST_RX: begin
                        if (scl_rise && cnt != FULL) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_bit};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && cnt == FULL) begin
                            if (state == ST_SEL) begin
                                if (sel_hit) begin
                                    sda_pull   <= 1'b1;
                                    rd_mode    <= sel_rd;
                                    first_pend <= ~sel_rd;
                                    state      <= ST_SACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                rx_byte    <= shreg;
                                rx_valid   <= 1'b1;
                                rx_first   <= first_pend;
                                first_pend <= 1'b0;
                                sda_pull   <= 1'b1;
                                state      <= ST_RACK;
                            end
                        end
                    end
                    ST_SACK: begin
                        if (scl_rise && rd_mode) begin
                            tx_req <= 1'b1;
                        end else if (scl_fall) begin
                            cnt <= '0;
                            if (rd_mode) begin
                                txsh     <= tx_byte;
                                sda_pull <= ~tx_byte[BYTE_W-1];
                                state    <= ST_TX;
                            end else begin
                                sda_pull <= 1'b0;
                                state    <= ST_RX;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b0;
                            cnt      <= '0;
                            state    <= ST_RX;
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (cnt == FULL) begin
                                sda_pull <= 1'b0;
                                state    <= ST_MACK;
                            end else begin
                                txsh     <= {txsh[BYTE_W-2:0], 1'b0};
                                sda_pull <= ~txsh[BYTE_W-2];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            ack_valid  <= 1'b1;
                            master_ack <= ~sda_bit;
                            mack_q     <= ~sda_bit;
                            tx_req     <= ~sda_bit;
                        end else if (scl_fall) begin
                            cnt <= '0;
                            if (mack_q) begin
                                txsh     <= tx_byte;
                                sda_pull <= ~tx_byte[BYTE_W-1];
                                state    <= ST_TX;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/twi_slave_front.sv
// Top: two-wire slave front end. Connects the line monitor, the select
// matcher and the byte engine. Assumes SCL and SDA are synchronised to clk
// and that each SCL level lasts several clk cycles.
module twi_slave_front
    import twi_pkg::*;
#(
    parameter logic [STRAP_W-1:0] STRAP_WIRED = '1,
    parameter logic [STRAP_W-1:0] STRAP_TIE   = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic [STRAP_W-1:0] strap,
    input  logic               busy,
    input  logic [BYTE_W-1:0]  tx_byte,
    output logic               sda_pull,
    output logic [BYTE_W-1:0]  rx_byte,
    output logic               rx_valid,
    output logic               rx_first,
    output logic               tx_req,
    output logic               ack_valid,
    output logic               master_ack,
    output logic               start_det,
    output logic               stop_det
);
    logic              sda_bit, scl_rise, scl_fall, start_seen, stop_seen;
    logic              sel_hit, sel_rd;
    logic [BYTE_W-1:0] shreg;

    twi_line_mon u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl_in),
        .sda_in     (sda_in),
        .sda_bit    (sda_bit),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_seen (start_seen),
        .stop_seen  (stop_seen)
    );

    twi_sel_match #(
        .STRAP_WIRED (STRAP_WIRED),
        .STRAP_TIE   (STRAP_TIE)
    ) u_match (
        .strap    (strap),
        .sel_byte (shreg),
        .busy     (busy),
        .sel_hit  (sel_hit),
        .sel_rd   (sel_rd)
    );

    twi_byte_engine u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_bit    (sda_bit),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_seen (start_seen),
        .stop_seen  (stop_seen),
        .sel_hit    (sel_hit),
        .sel_rd     (sel_rd),
        .tx_byte    (tx_byte),
        .shreg      (shreg),
        .sda_pull   (sda_pull),
        .rx_byte    (rx_byte),
        .rx_valid   (rx_valid),
        .rx_first   (rx_first),
        .tx_req     (tx_req),
        .ack_valid  (ack_valid),
        .master_ack (master_ack),
        .start_det  (start_det),
        .stop_det   (stop_det)
    );
endmodule

// File: rtl/twi_slave_chk.sv
// Checker: temporal properties of the front end's ports, attached by bind.
// Assumes a legal master (no start or stop while the slave pulls SDA low).
module twi_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_in,
    input logic sda_pull,
    input logic rx_valid,
    input logic rx_first,
    input logic ack_valid,
    input logic start_det,
    input logic stop_det
);
    // R9
    pull_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (!sda_pull && !rx_valid && !ack_valid && !start_det && !stop_det));

    // R7
    pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> !scl_in);

    // R1
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |-> !sda_pull);

    // R2
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |-> !sda_pull);

    // R6
    first_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_first |-> rx_valid);

    // R8
    mack_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> !sda_pull);

    // R1
    event_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_det, stop_det, rx_valid, ack_valid}));
endmodule

bind twi_slave_front twi_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_pull  (sda_pull),
    .rx_valid  (rx_valid),
    .rx_first  (rx_first),
    .ack_valid (ack_valid),
    .start_det (start_det),
    .stop_det  (stop_det)
);

// File: tb/sim_twi_slave_front.sv
module sim_twi_slave_front;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       busy = 1'b0;
    logic [2:0] strap = 3'b011;
    logic [7:0] tx_byte = 8'h00;
    wire        sda_bus;
    logic       sda_pull, rx_valid, rx_first, tx_req, ack_valid, master_ack;
    logic       start_det, stop_det;
    logic [7:0] rx_byte;

    always #10 clk = ~clk;

    assign sda_bus = m_sda & ~sda_pull;

    twi_slave_front #(.STRAP_WIRED(3'b110), .STRAP_TIE(3'b000)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
        .strap(strap), .busy(busy), .tx_byte(tx_byte), .sda_pull(sda_pull),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_first(rx_first),
        .tx_req(tx_req), .ack_valid(ack_valid), .master_ack(master_ack),
        .start_det(start_det), .stop_det(stop_det)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_tx(input int k);
        return 8'hC3 + 8'(k * 37);
    endfunction

    // Event monitor and command-engine model, sampled at the falling clock.
    int         c_start = 0, c_stop = 0, c_rx = 0, c_ack = 0, c_txreq = 0, c_viol = 0;
    logic [7:0] rx_log [64];
    logic       first_log [64];
    logic       ack_log [64];
    logic       prev_scl = 1'b1, prev_pull = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (start_det) c_start++;
            if (stop_det)  c_stop++;
            if (rx_valid) begin
                rx_log[c_rx % 64]    = rx_byte;
                first_log[c_rx % 64] = rx_first;
                c_rx++;
            end
            if (ack_valid) begin
                ack_log[c_ack % 64] = master_ack;
                c_ack++;
            end
            if (tx_req) begin
                tx_byte = exp_tx(c_txreq);
                c_txreq++;
            end
            if (m_scl && prev_scl && (sda_pull != prev_pull)) c_viol++;
        end
        prev_scl  = m_scl;
        prev_pull = sda_pull;
    end

    task automatic hold();
        repeat (HALF) @(posedge clk);
    endtask

    task automatic m_start();
        m_sda = 1'b1; hold();
        m_scl = 1'b1; hold();
        m_sda = 1'b0; hold();
        m_scl = 1'b0; hold();
    endtask

    task automatic m_stop();
        m_sda = 1'b0; hold();
        m_scl = 1'b1; hold();
        m_sda = 1'b1; hold();
    endtask

    task automatic m_bit(input logic b, output logic seen);
        m_sda = b; hold();
        m_scl = 1'b1;
        repeat (HALF / 2) @(posedge clk);
        @(negedge clk) seen = sda_bus;
        repeat (HALF / 2) @(posedge clk);
        m_scl = 1'b0;
    endtask

    task automatic m_write(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) m_bit(b[i], s);
        m_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic m_read(output logic [7:0] b, input logic give_ack);
        logic s;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            m_bit(1'b1, s);
            b = {b[6:0], s};
        end
        m_bit(~give_ack, s);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 pull in reset", sda_pull, 0);
        check("R9 strobes in reset", {rx_valid, tx_req, ack_valid, start_det, stop_det}, 0);
        rst_n = 1'b1;
        hold();
    endtask

    task automatic t_write();
        logic a;
        int   r0 = c_rx, s0 = c_start, p0 = c_stop;
        m_start();
        m_write(8'hA4, a); check("R4 select ack", a, 1);
        m_write(8'h3C, a); check("R4 data ack 0", a, 1);
        m_write(8'hA5, a); check("R4 data ack 1", a, 1);
        m_write(8'h01, a); check("R4 data ack 2", a, 1);
        m_stop();
        hold();
        check("R6 rx count", c_rx - r0, 3);
        check("R6 byte 0", rx_log[r0 % 64], 8'h3C);
        check("R6 byte 1", rx_log[(r0 + 1) % 64], 8'hA5);
        check("R6 byte 2", rx_log[(r0 + 2) % 64], 8'h01);
        check("R6 first flags", {first_log[r0 % 64], first_log[(r0 + 1) % 64], first_log[(r0 + 2) % 64]}, 3'b100);
        check("R1 start count", c_start - s0, 1);
        check("R2 stop count", c_stop - p0, 1);
        check("R2 released after stop", sda_pull, 0);
    endtask

    task automatic t_strap();
        logic a;
        int   r0 = c_rx;
        m_start(); m_write(8'hA6, a); check("R10 tied A0 blocks pin value", a, 0);
        m_write(8'h55, a); check("R3 ignored after mismatch", a, 0);
        m_stop();
        m_start(); m_write(8'hAC, a); check("R3 A2 mismatch nack", a, 0); m_stop();
        m_start(); m_write(8'hB4, a); check("R3 prefix mismatch nack", a, 0); m_stop();
        m_start(); m_write(8'hA4, a); check("R10 A0 pin high ignored", a, 1); m_stop();
        strap = 3'b001;
        m_start(); m_write(8'hA4, a); check("R3 wired A1 now low nack", a, 0); m_stop();
        m_start(); m_write(8'hA0, a); check("R3 wired A1 low ack", a, 1); m_stop();
        strap = 3'b011;
        hold();
        check("R3 no rx after mismatch", c_rx - r0, 0);
    endtask

    task automatic t_busy();
        logic a;
        busy = 1'b1;
        m_start(); m_write(8'hA4, a); check("R5 busy write select nack", a, 0); m_stop();
        m_start(); m_write(8'hA5, a); check("R5 busy read select nack", a, 0); m_stop();
        busy = 1'b0;
        m_start(); m_write(8'hA4, a); check("R5 ack after busy clears", a, 1); m_stop();
    endtask

    task automatic t_read();
        logic       a;
        logic [7:0] d;
        int         t0 = c_txreq, k0 = c_ack, v0 = c_viol;
        m_start();
        m_write(8'hA5, a); check("R4 read select ack", a, 1);
        m_read(d, 1'b1); check("R7 read byte 0", d, exp_tx(t0));
        m_read(d, 1'b1); check("R7 read byte 1", d, exp_tx(t0 + 1));
        m_read(d, 1'b0); check("R7 read byte 2", d, exp_tx(t0 + 2));
        check("R7 tx_req count", c_txreq - t0, 3);
        check("R8 ack reports", {ack_log[k0 % 64], ack_log[(k0 + 1) % 64], ack_log[(k0 + 2) % 64]}, 3'b110);
        m_read(d, 1'b0); check("R8 released after nack", d, 8'hFF);
        check("R8 no request after nack", c_txreq - t0, 3);
        m_stop();
        hold();
        check("R7 pull stable while SCL high", c_viol - v0, 0);
    endtask

    task automatic t_abort();
        logic       a, s;
        logic [7:0] d;
        int         r0 = c_rx, s0 = c_start;
        m_start();
        m_write(8'hA4, a);
        m_write(8'h11, a);
        for (int i = 0; i < 4; i++) m_bit(1'b1, s);
        m_start();
        m_write(8'hA4, a); check("R1 select after abort ack", a, 1);
        m_write(8'h22, a);
        m_start();
        m_write(8'hA5, a); check("R1 read after repeated start ack", a, 1);
        m_read(d, 1'b0); check("R1 read data after repeated start", d, exp_tx(c_txreq - 1));
        m_stop();
        hold();
        check("R1 rx count, partial byte dropped", c_rx - r0, 2);
        check("R1 bytes", {rx_log[r0 % 64], rx_log[(r0 + 1) % 64]}, 16'h1122);
        check("R6 first flag per select", {first_log[r0 % 64], first_log[(r0 + 1) % 64]}, 2'b11);
        check("R1 start count", c_start - s0, 3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_write();
        t_strap();
        t_busy();
        t_read();
        t_abort();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule